// File: doc/BRIEF.md
# Serial Interrupt Line Agent

This block is the peripheral end of a single-wire, shared, open-collector style interrupt bus. A host opens each cycle of the bus with a low pulse called the start frame. The host then runs a fixed number of three-clock data frames and closes with a low pulse called the stop frame. The agent watches the line level. It synchronises to the clock on which the line returns high after the start frame, and counts frames and phases from that clock. In the frame whose index matches its slot input, it reports the level of its local interrupt input through a pair of pad enables, one pulling the line low and one pulling it high.

The width of the stop frame tells the agent which bus mode comes next. In continuous mode only the host opens cycles. In quiet mode the bus sits idle and high, and the agent may open a cycle itself when its interrupt level has changed since it last reported. It pulls the line low for exactly one clock and then hands the rest of the start frame to the host. Any low pulse that follows the last data frame is taken as the stop frame. After reset the agent assumes continuous mode and keeps both enables off until a complete start frame has gone by.

Top module: `seriq_agent`

## Requirements
- R1: Let E be the first rising clock edge after a start frame at which the line is sampled high. The start frame may be any number of low clocks. The sample phase of slot k then occupies the clock that follows edge E+1+3k. The recovery phase follows edge E+2+3k, and the turn-around phase follows edge E+3+3k.
- R2: In the sample phase of its own slot, driveLow is 1 when irqIn is 0 and 0 when irqIn is 1.
- R3: driveHigh is 1 in the recovery phase of its own slot only if the agent pulled the line low in the sample phase just before it. In every other case driveHigh is 0.
- R4: In the turn-around phase, in every other slot, and in the clock after edge E, both enables are 0. driveLow and driveHigh are never 1 together.
- R5: A slotNum of NUM_FRAMES or more never matches a frame, so the agent never drives during data frames.
- R6: The first low sample after the last turn-around phase opens the stop frame. The agent counts the low samples. A count of exactly 2 selects quiet mode, and any other count selects continuous mode.
- R7: In quiet mode, with the line sampled high between cycles, a difference between irqIn and the level last reported in the agent's own sample phase makes driveLow 1 for exactly one clock. Before any report, that level is 1. The host then completes the start frame and the agent follows the new cycle.
- R8: There is no such request when irqIn still equals the level last reported, nor at any time in continuous mode.
- R9: During reset and after it, both enables stay 0 until a complete start frame has been seen on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineIn | input | 1 | Level sampled on the shared interrupt line |
| irqIn | input | 1 | Local interrupt level; 0 is reported as a low sample |
| slotNum | input | SLOT_W | Data frame index assigned to this agent |
| driveLow | output | 1 | Pad enable pulling the line low |
| driveHigh | output | 1 | Pad enable pulling the line high |

## Verification
The bench sweeps every slot number, including two beyond the last frame, with both interrupt levels and start frames of 4, 6 and 8 clocks. It compares every clock of every cycle against a position computed from the release edge. An off-by-one in the synchronisation would move the report into a neighbour's slot, and a missing recovery qualifier would pull the line high in frames where it was never pulled low. Stop frames of 2, 3 and 5 clocks are followed by idle stretches with the interrupt level held or toggled. A stop-frame width counted wrongly would open a cycle in continuous mode or stay silent in quiet mode. The agent-opened cycle is checked for a one-clock pulse and for correct frame counting once the host takes over.

// File: rtl/seriq_pkg.sv
package seriq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_START,
    ST_SYNC,
    ST_DATA,
    ST_STOPWAIT,
    ST_STOP
  } seriq_state_t;

  typedef enum logic [1:0] {
    PH_SAMPLE = 2'd0,
    PH_RECOV  = 2'd1,
    PH_TURN   = 2'd2
  } seriq_phase_t;

  typedef struct packed {
    logic frameClr;
    logic phaseAdv;
    logic lowStart;
    logic lowInc;
    logic modeLatch;
    logic reqDrive;
    logic inData;
  } seriq_strobe_t;

endpackage

// File: rtl/seriq_ctrl.sv
module seriq_ctrl
  import seriq_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          lineIn,
  input  logic          lastSlotEnd,
  input  logic          quietMode,
  input  logic          irqChanged,
  output seriq_strobe_t stb
);

  seriq_state_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (!lineIn)                      stateNext = ST_START;
        else if (quietMode && irqChanged) stateNext = ST_REQ;
      end
      ST_REQ:      stateNext = ST_START;
      ST_START:    if (lineIn) stateNext = ST_SYNC;
      ST_SYNC:     stateNext = ST_DATA;
      ST_DATA:     if (lastSlotEnd) stateNext = ST_STOPWAIT;
      ST_STOPWAIT: if (!lineIn) stateNext = ST_STOP;
      ST_STOP:     if (lineIn) stateNext = ST_IDLE;
      default:     stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stb.frameClr  = (state == ST_SYNC);
    stb.phaseAdv  = (state == ST_DATA);
    stb.lowStart  = (state == ST_STOPWAIT) && !lineIn;
    stb.lowInc    = (state == ST_STOP) && !lineIn;
    stb.modeLatch = (state == ST_STOP) && lineIn;
    stb.reqDrive  = (state == ST_REQ);
    stb.inData    = (state == ST_DATA);
  end

endmodule

// File: rtl/seriq_dp.sv
module seriq_dp
  import seriq_pkg::*;
#(
  parameter int NUM_FRAMES = 21,
  parameter int SLOT_W     = 5,
  parameter int LOW_W      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  seriq_strobe_t     stb,
  input  logic              irqIn,
  input  logic [SLOT_W-1:0] slotNum,
  output logic              lastSlotEnd,
  output logic              quietMode,
  output logic              irqChanged,
  output logic              driveLow,
  output logic              driveHigh
);

  localparam int FRAME_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1;
  localparam logic [FRAME_W-1:0] LAST_FRAME = FRAME_W'(NUM_FRAMES - 1);
  localparam logic [LOW_W-1:0]   LOW_MAX    = '1;
  localparam logic [LOW_W-1:0]   QUIET_LEN  = LOW_W'(2);

  logic [FRAME_W-1:0] frameIdx;
  seriq_phase_t       phase;
  logic [LOW_W-1:0]   lowCnt;
  logic               lastIrq;
  logic               drovLow;
  logic               mine;

  // frame / phase position inside the data stream
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameIdx <= '0;
      phase    <= PH_SAMPLE;
    end else if (stb.frameClr) begin
      frameIdx <= '0;
      phase    <= PH_SAMPLE;
    end else if (stb.phaseAdv) begin
      unique case (phase)
        PH_SAMPLE: phase <= PH_RECOV;
        PH_RECOV:  phase <= PH_TURN;
        default: begin
          phase    <= PH_SAMPLE;
          frameIdx <= frameIdx + FRAME_W'(1);
        end
      endcase
    end
  end

  // stop frame width measurement and mode selection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowCnt    <= '0;
      quietMode <= 1'b0;
    end else begin
      if (stb.lowStart)
        lowCnt <= LOW_W'(1);
      else if (stb.lowInc && lowCnt != LOW_MAX)
        lowCnt <= lowCnt + LOW_W'(1);
      if (stb.modeLatch)
        quietMode <= (lowCnt == QUIET_LEN);
    end
  end

  assign mine = stb.inData && (32'(slotNum) == 32'(frameIdx));

  // record what was reported in the own sample phase
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastIrq <= 1'b1;
      drovLow <= 1'b0;
    end else if (stb.inData && phase == PH_SAMPLE) begin
      drovLow <= mine && !irqIn;
      if (mine) lastIrq <= irqIn;
    end
  end

  assign lastSlotEnd = (frameIdx == LAST_FRAME) && (phase == PH_TURN);
  assign irqChanged  = (irqIn != lastIrq);
  assign driveLow    = stb.reqDrive || (mine && phase == PH_SAMPLE && !irqIn);
  assign driveHigh   = mine && phase == PH_RECOV && drovLow;

endmodule

// File: rtl/seriq_agent.sv
module seriq_agent
  import seriq_pkg::*;
#(
  parameter int NUM_FRAMES = 21,
  parameter int SLOT_W     = 5,
  parameter int LOW_W      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineIn,
  input  logic              irqIn,
  input  logic [SLOT_W-1:0] slotNum,
  output logic              driveLow,
  output logic              driveHigh
);

  seriq_strobe_t stb;
  logic lastSlotEnd, quietMode, irqChanged;

  seriq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .lineIn(lineIn),
    .lastSlotEnd(lastSlotEnd), .quietMode(quietMode),
    .irqChanged(irqChanged), .stb(stb)
  );

  seriq_dp #(.NUM_FRAMES(NUM_FRAMES), .SLOT_W(SLOT_W), .LOW_W(LOW_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .irqIn(irqIn), .slotNum(slotNum),
    .lastSlotEnd(lastSlotEnd), .quietMode(quietMode), .irqChanged(irqChanged),
    .driveLow(driveLow), .driveHigh(driveHigh)
  );

endmodule

// File: rtl/seriq_agent_chk.sv
module seriq_agent_chk (
  input logic clk,
  input logic rstN,
  input logic lineIn,
  input logic driveLow,
  input logic driveHigh
);

  logic prevLine, seenStart;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevLine  <= 1'b1;
      seenStart <= 1'b0;
    end else begin
      prevLine <= lineIn;
      if (!prevLine && lineIn) seenStart <= 1'b1;
    end
  end

  // R4
  drive_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(driveLow && driveHigh));

  // R3
  high_after_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    driveHigh |-> $past(driveLow));

  // R4
  turn_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    driveHigh |=> (!driveLow && !driveHigh));

  // R7
  low_one_clock_chk: assert property (@(posedge clk) disable iff (!rstN)
    driveLow |=> !driveLow);

  // R9
  no_drive_before_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (driveLow || driveHigh) |-> seenStart);

endmodule

bind seriq_agent seriq_agent_chk u_chk (
  .clk(clk), .rstN(rstN), .lineIn(lineIn),
  .driveLow(driveLow), .driveHigh(driveHigh)
);

// File: tb/seriq_agent_tb.sv
module seriq_agent_tb;

  localparam int NF  = 6;
  localparam int SW  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostLow = 1'b0;
  logic irqIn = 1'b1;
  logic [SW-1:0] slotNum = '0;
  logic driveLow, driveHigh;
  logic lineIn;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  assign lineIn = !(hostLow || driveLow);

  always #10 clk = ~clk;

  seriq_agent #(.NUM_FRAMES(NF), .SLOT_W(SW), .LOW_W(3)) u_dut (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .irqIn(irqIn),
    .slotNum(slotNum), .driveLow(driveLow), .driveHigh(driveHigh)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkIdle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(!driveLow && !driveHigh, req, {driveLow, driveHigh}, 0);
    end
  endtask

  // start frame (host or agent opened), data frames, stop frame
  task automatic runCycle(input int startLen, input bit agentOpens, input int stopLen);
    bit seen = 0;
    if (agentOpens) begin
      for (int i = 0; i < 4 && !seen; i++) begin
        @(negedge clk);
        if (driveLow) seen = 1;
      end
      check(seen, "R7 request pulse", seen, 1);
    end
    if (seen) begin
      hostLow = 1'b1;
      @(negedge clk);
      check(!driveLow, "R7 release after one clock", driveLow, 0);
      repeat (startLen - 2) @(negedge clk);
      hostLow = 1'b0;
    end else begin
      @(negedge clk);
      hostLow = 1'b1;
      repeat (startLen) @(negedge clk);
      hostLow = 1'b0;
    end
    // clock after edge E
    @(negedge clk);
    check(!driveLow && !driveHigh, "R4 sync clock", {driveLow, driveHigh}, 0);
    for (int p = 0; p < 3 * NF; p++) begin
      int fr = p / 3;
      int ph = p % 3;
      bit expL = (fr == int'(slotNum)) && ph == 0 && !irqIn;
      bit expH = (fr == int'(slotNum)) && ph == 1 && !irqIn;
      string req;
      @(negedge clk);
      if (int'(slotNum) >= NF) req = "R5";
      else if (ph == 0)        req = "R1/R2 sample";
      else if (ph == 1)        req = "R3 recovery";
      else                     req = "R4 turn-around";
      check(driveLow == expL, req, driveLow, expL);
      check(driveHigh == expH, req, driveHigh, expH);
    end
    @(negedge clk);
    hostLow = 1'b1;
    repeat (stopLen) @(negedge clk);
    hostLow = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!driveLow && !driveHigh, "R9 reset", {driveLow, driveHigh}, 0);
    rstN = 1'b1;
    irqIn = 1'b0;
    slotNum = '0;
    checkIdle(10, "R9 before start frame");

    // R1 R2 R3 R4 R5 sweep over slots, levels and start widths
    for (int s = 0; s < (1 << SW); s++) begin
      for (int lv = 0; lv < 2; lv++) begin
        slotNum = SW'(s);
        irqIn = lv[0];
        runCycle(4 + 2 * (s % 3), 1'b0, 3);
        checkIdle(2, "R8 continuous idle");
      end
    end

    // R6 quiet after 2-clock stop, R8 unchanged level
    slotNum = SW'(2);
    irqIn = 1'b1;
    runCycle(4, 1'b0, 2);
    checkIdle(6, "R8 quiet unchanged");
    // R7 agent opens a cycle on change
    irqIn = 1'b0;
    runCycle(4, 1'b1, 3);
    // R6 continuous after 3-clock stop; R8 no request on change
    irqIn = 1'b1;
    checkIdle(8, "R8 continuous changed");
    runCycle(6, 1'b0, 2);
    irqIn = 1'b0;
    runCycle(8, 1'b1, 5);
    // R6 width 5 selects continuous
    irqIn = 1'b1;
    checkIdle(8, "R6 wide stop continuous");
    runCycle(4, 1'b0, 2);
    checkIdle(4, "R8 quiet unchanged again");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule